// File: doc/BRIEF.md
# Slot Reset and Power-Good Sequencer

This block sits beside the power mode controller of a removable-card slot and turns the slot's state into three logic signals. It drives the card reset line (active low), it pulls the shared reference-clock-enable line low while the slot's power is not good, and it drives an overcurrent flag. The clock-enable and overcurrent pins are open drain. Each is modelled here as a drive-low request bit. The real level of the clock-enable line is read back, because the host may hold it low to keep the card in reset.

Card reset is released only when four conditions hold together: the slot is in the powered mode, every output rail has been good for a settling interval, system reset is inactive, and the clock-enable line reads high. Once asserted, card reset stays low for at least a minimum width. A change of system reset reaches the card reset within a few clock cycles and does not wait for the settling interval. The raw overcurrent indication is filtered in both directions, so the flag moves only after the raw level has stayed at its new value for a full deglitch interval. All intervals are counted in clock cycles from one cycles-per-microsecond parameter. Every input other than the slot mode is asynchronous and passes through a two-flop synchronizer.

Top module: `slot_reset_seq`

## Requirements
- R1: While `rst_n` is low and on the first cycle after it is released, `card_rst_n` is 0 and `oc_pull_low` is 0.
- R2: `slot_mode` encodes 0 = off, 1 = shutdown, 2 = empty slot, 3 = standby and 4 = powered. If `slot_mode` is not 4 at a clock edge, `card_rst_n` is 0 after that edge.
- R3: If any bit of `rail_good` is 0 at a clock edge, `card_rst_n` is 0 no later than three edges after it.
- R4: `card_rst_n` rises only after the slot has been in mode 4 with all synchronized rail flags at 1 for at least SETTLE_CYC = RELEASE_US × CYCLES_PER_US consecutive cycles. If those conditions are then met, it rises at the first edge on which the remaining conditions of R5, R6 and R7 also hold.
- R5: `sys_rst_n` at 0 forces `card_rst_n` to 0 within three edges. A return of `sys_rst_n` to 1 releases `card_rst_n` within three edges when the other conditions already hold, with no new settling interval.
- R6: Every low pulse of `card_rst_n` lasts at least WIDTH_CYC = MIN_RESET_US × CYCLES_PER_US cycles, even when its cause lasts a shorter time.
- R7: If `clken_pin` reads 0 (the host holds the line low), `card_rst_n` is 0 within three edges.
- R8: `clken_pull_low` is 0 in mode 0 (line left floating) and is 0 in mode 4 when all synchronized rail flags are 1. In every other case it is 1. A change in the rail flags reaches it two edges later, and a change of mode reaches it in the same cycle.
- R9: `oc_pull_low` = 1 signals overcurrent. It takes the synchronized value of `oc_raw` only after that value has differed from the flag on DG_CYC = DEGLITCH_US × CYCLES_PER_US consecutive edges. This filter applies on entry to and on exit from the overcurrent condition.
- R10: An `oc_raw` pulse, or a gap in it, that is shorter than DG_CYC cycles leaves `oc_pull_low` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| slot_mode | input | 3 | Slot mode from the power mode controller (encoding in R2), synchronous to `clk` |
| rail_good | input | NUM_RAILS | Per-rail output power-good flags, asynchronous |
| sys_rst_n | input | 1 | System reset, active low, asynchronous |
| clken_pin | input | 1 | Sensed level of the shared clock-enable line |
| oc_raw | input | 1 | Raw overcurrent indication, 1 = overcurrent |
| card_rst_n | output | 1 | Card reset, active low |
| clken_pull_low | output | 1 | Request to pull the clock-enable line low |
| oc_pull_low | output | 1 | Request to pull the overcurrent flag line low (flag asserted) |

## Verification
The bound checker checks on every cycle the hard limits on card reset: it is low outside the powered mode, and it falls within three edges of a rail fault, a system reset or a held-low clock-enable line. It also checks that each rising edge of card reset comes after both the settling run and the minimum width, that the clock-enable line floats in the off mode, and that the overcurrent flag never moves before a full mismatch run and moves only to the synchronized raw value. The bench's scenarios show what a property cannot pin to the cycle. These are the exact release cycle after settling, the fast release when system reset returns, the stretching of a short reset pulse, the two-edge lag of the clock-enable request, and the rejection of overcurrent glitches and gaps.

// File: rtl/slot_seq_pkg.sv
// Shared definitions for the slot reset sequencer.
// Assumes the slot mode arrives from a controller running on the same clock.
package slot_seq_pkg;

    // Slot mode encoding supplied by the power mode controller.
    typedef enum logic [2:0] {
        SLOT_OFF      = 3'd0,
        SLOT_SHUTDOWN = 3'd1,
        SLOT_EMPTY    = 3'd2,
        SLOT_STANDBY  = 3'd3,
        SLOT_POWERED  = 3'd4
    } slot_mode_e;

    // Width of a counter that must hold values 0..max_val.
    function automatic int cnt_width(input int max_val);
        return (max_val < 2) ? 1 : $clog2(max_val + 1);
    endfunction

endpackage

// File: rtl/slot_sync.sv
// Two-flop synchronizer, one chain per bit.
// Assumes each bit is an independent level: no bus coherence is promised.
// During reset both stages clear to 0.
module slot_sync #(
    parameter int WIDTH = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        logic meta_q;
        logic sync_q;

        // Capture the asynchronous bit, then retime it once more.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                meta_q <= 1'b0;
                sync_q <= 1'b0;
            end else begin
                meta_q <= d[i];
                sync_q <= meta_q;
            end
        end

        assign q[i] = sync_q;
    end

endmodule

// File: rtl/slot_rst_timer.sv
// Card reset generator with a settling delay and a minimum pulse width.
// Assumes all inputs are synchronous. power_ok must already include the
// slot mode and all rail flags. The settling delay applies only to power_ok.
// The system-reset and clock-enable conditions release without extra delay.
module slot_rst_timer #(
    parameter int SETTLE_CYC = 500000,
    parameter int WIDTH_CYC  = 5000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic power_ok,
    input  logic sys_ok,
    input  logic clken_ok,
    output logic card_rst_n
);

    localparam int SW = slot_seq_pkg::cnt_width(SETTLE_CYC);
    localparam int WW = slot_seq_pkg::cnt_width(WIDTH_CYC);
    localparam logic [SW-1:0] SETTLE_MAX = SW'(SETTLE_CYC);
    localparam logic [WW-1:0] WIDTH_MAX  = WW'(WIDTH_CYC);

    logic [SW-1:0] settle_q;
    logic [WW-1:0] width_q;
    logic          card_q;
    logic          settle_done;
    logic          width_done;
    logic          release_ok;

    // Count consecutive cycles of good power, saturating at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n)                  settle_q <= '0;
        else if (!power_ok)          settle_q <= '0;
        else if (settle_q != SETTLE_MAX) settle_q <= settle_q + 1'b1;
    end

    // Count cycles spent with the card held in reset, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n)                  width_q <= '0;
        else if (card_q)             width_q <= '0;
        else if (width_q != WIDTH_MAX) width_q <= width_q + 1'b1;
    end

    assign settle_done = (settle_q == SETTLE_MAX);
    assign width_done  = (width_q == WIDTH_MAX);
    assign release_ok  = power_ok & settle_done & sys_ok & clken_ok;

    // Drop reset at once on any fault; raise it only after the minimum width.
    always_ff @(posedge clk) begin
        if (!rst_n)      card_q <= 1'b0;
        else if (card_q) card_q <= release_ok;
        else             card_q <= release_ok & width_done;
    end

    assign card_rst_n = card_q;

endmodule

// File: rtl/slot_oc_filter.sv
// Symmetric deglitch filter for the overcurrent flag.
// Assumes oc_in is already synchronized. The flag follows oc_in only after
// DG_CYC consecutive edges on which the two differ, in either direction.
module slot_oc_filter #(
    parameter int DG_CYC = 500000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic oc_in,
    output logic oc_flag
);

    localparam int CW = (DG_CYC < 2) ? 1 : $clog2(DG_CYC);
    localparam logic [CW-1:0] LAST = CW'(DG_CYC - 1);

    logic [CW-1:0] run_q;
    logic          flag_q;

    // Track the mismatch run and flip the flag when it completes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q  <= '0;
            flag_q <= 1'b0;
        end else if (oc_in == flag_q) begin
            run_q  <= '0;
        end else if (run_q == LAST) begin
            run_q  <= '0;
            flag_q <= oc_in;
        end else begin
            run_q  <= run_q + 1'b1;
        end
    end

    assign oc_flag = flag_q;

endmodule

// File: rtl/slot_reset_seq.sv
// Slot reset and power-good sequencer, top level.
// Assumes slot_mode is synchronous to clk. All other inputs are asynchronous
// and are synchronized here. The open-drain pins are presented as
// drive-low request bits; the pad drivers are outside this block.
module slot_reset_seq #(
    parameter int CYCLES_PER_US = 50,
    parameter int RELEASE_US    = 10000,
    parameter int DEGLITCH_US   = 10000,
    parameter int MIN_RESET_US  = 100,
    parameter int NUM_RAILS     = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [2:0]           slot_mode,
    input  logic [NUM_RAILS-1:0] rail_good,
    input  logic                 sys_rst_n,
    input  logic                 clken_pin,
    input  logic                 oc_raw,
    output logic                 card_rst_n,
    output logic                 clken_pull_low,
    output logic                 oc_pull_low
);
    import slot_seq_pkg::*;

    localparam int SETTLE_CYC = RELEASE_US * CYCLES_PER_US;
    localparam int WIDTH_CYC  = MIN_RESET_US * CYCLES_PER_US;
    localparam int DG_CYC     = DEGLITCH_US * CYCLES_PER_US;
    localparam int SYNC_W     = NUM_RAILS + 3;

    logic [SYNC_W-1:0]    async_in;
    logic [SYNC_W-1:0]    sync_out;
    logic [NUM_RAILS-1:0] rail_s;
    logic                 sys_s;
    logic                 clken_s;
    logic                 oc_s;
    logic                 powered;
    logic                 rails_ok;
    logic                 power_ok;

    // Gather every asynchronous input into one synchronizer bank.
    assign async_in = {sys_rst_n, clken_pin, oc_raw, rail_good};

    slot_sync #(.WIDTH(SYNC_W)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (async_in),
        .q     (sync_out)
    );

    assign rail_s  = sync_out[NUM_RAILS-1:0];
    assign oc_s    = sync_out[NUM_RAILS];
    assign clken_s = sync_out[NUM_RAILS+1];
    assign sys_s   = sync_out[NUM_RAILS+2];

    // Power is good only in the powered mode with every rail flag set.
    assign powered  = (slot_mode == SLOT_POWERED);
    assign rails_ok = &rail_s;
    assign power_ok = powered & rails_ok;

    // Undelayed power-good on the shared line: float when off, else pull low until good.
    assign clken_pull_low = (slot_mode != SLOT_OFF) & ~power_ok;

    slot_rst_timer #(
        .SETTLE_CYC (SETTLE_CYC),
        .WIDTH_CYC  (WIDTH_CYC)
    ) u_rst (
        .clk        (clk),
        .rst_n      (rst_n),
        .power_ok   (power_ok),
        .sys_ok     (sys_s),
        .clken_ok   (clken_s),
        .card_rst_n (card_rst_n)
    );

    slot_oc_filter #(.DG_CYC(DG_CYC)) u_oc (
        .clk     (clk),
        .rst_n   (rst_n),
        .oc_in   (oc_s),
        .oc_flag (oc_pull_low)
    );

endmodule

// File: rtl/slot_reset_seq_chk.sv
// Property checker for slot_reset_seq, attached with bind below.
// Assumes the synchronized rail and overcurrent bits of the top are visible
// by name, so that run counters can be kept on the retimed values.
module slot_reset_seq_chk #(
    parameter int SETTLE_CYC = 1,
    parameter int WIDTH_CYC  = 1,
    parameter int DG_CYC     = 1,
    parameter int NUM_RAILS  = 3
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [2:0]           slot_mode,
    input logic [NUM_RAILS-1:0] rail_good,
    input logic [NUM_RAILS-1:0] rail_s,
    input logic                 sys_rst_n,
    input logic                 clken_pin,
    input logic                 oc_s,
    input logic                 card_rst_n,
    input logic                 clken_pull_low,
    input logic                 oc_pull_low
);

    int good_run;
    int low_run;
    int mis_run;

    // Length of the current run of powered mode with all synchronized rails good.
    always_ff @(posedge clk) begin
        if (!rst_n)                                good_run <= 0;
        else if (slot_mode == 3'd4 && (&rail_s))   good_run <= (good_run < SETTLE_CYC + 4) ? good_run + 1 : good_run;
        else                                       good_run <= 0;
    end

    // Length of the current low pulse on card reset.
    always_ff @(posedge clk) begin
        if (!rst_n)          low_run <= 0;
        else if (!card_rst_n) low_run <= (low_run < WIDTH_CYC + 4) ? low_run + 1 : low_run;
        else                 low_run <= 0;
    end

    // Length of the current run where the synchronized raw value differs from the flag.
    always_ff @(posedge clk) begin
        if (!rst_n)                  mis_run <= 0;
        else if (oc_s != oc_pull_low) mis_run <= (mis_run < DG_CYC + 4) ? mis_run + 1 : mis_run;
        else                         mis_run <= 0;
    end

    p_mode_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_mode != 3'd4) |=> !card_rst_n);

    p_rail_fault_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(&$past(rail_good, 3)) |-> !card_rst_n);

    p_settle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(card_rst_n) |-> (good_run >= SETTLE_CYC));

    p_sys_rst_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(sys_rst_n, 3) |-> !card_rst_n);

    p_min_width_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(card_rst_n) |-> (low_run >= WIDTH_CYC));

    p_clken_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(clken_pin, 3) |-> !card_rst_n);

    p_off_float_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_mode == 3'd0) |-> !clken_pull_low);

    p_oc_dwell_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(oc_pull_low) |-> (mis_run >= DG_CYC));

    p_oc_follow_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(oc_pull_low) |-> (oc_pull_low == $past(oc_s)));

endmodule

bind slot_reset_seq slot_reset_seq_chk #(
    .SETTLE_CYC (SETTLE_CYC),
    .WIDTH_CYC  (WIDTH_CYC),
    .DG_CYC     (DG_CYC),
    .NUM_RAILS  (NUM_RAILS)
) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .slot_mode      (slot_mode),
    .rail_good      (rail_good),
    .rail_s         (rail_s),
    .sys_rst_n      (sys_rst_n),
    .clken_pin      (clken_pin),
    .oc_s           (oc_s),
    .card_rst_n     (card_rst_n),
    .clken_pull_low (clken_pull_low),
    .oc_pull_low    (oc_pull_low)
);

// File: tb/slot_reset_seq_test.sv
// Bench for slot_reset_seq: a behavioural reference model is compared with
// the design after every clock edge. Short intervals keep the run brief.
module slot_reset_seq_test;

    localparam int S_CYC = 40;   // settling cycles
    localparam int W_CYC = 12;   // minimum reset width
    localparam int D_CYC = 30;   // deglitch cycles

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] slot_mode = 3'd2;
    logic [2:0] rail_good = 3'b000;
    logic       sys_rst_n = 1'b1;
    logic       host_hold = 1'b0;
    logic       oc_raw = 1'b0;
    logic       clken_pin;
    logic       card_rst_n;
    logic       clken_pull_low;
    logic       oc_pull_low;

    int    n_checks = 0;
    int    n_fails  = 0;
    bit    finished = 1'b0;
    string phase = "R1";

    always #10 clk = ~clk;

    // Open-drain line: low if the block or the host pulls it, high otherwise.
    assign clken_pin = ~(clken_pull_low | host_hold);

    slot_reset_seq #(
        .CYCLES_PER_US (1),
        .RELEASE_US    (S_CYC),
        .DEGLITCH_US   (D_CYC),
        .MIN_RESET_US  (W_CYC),
        .NUM_RAILS     (3)
    ) uut (
        .clk            (clk),
        .rst_n          (rst_n),
        .slot_mode      (slot_mode),
        .rail_good      (rail_good),
        .sys_rst_n      (sys_rst_n),
        .clken_pin      (clken_pin),
        .oc_raw         (oc_raw),
        .card_rst_n     (card_rst_n),
        .clken_pull_low (clken_pull_low),
        .oc_pull_low    (oc_pull_low)
    );

    task automatic check_bit(input string what, input logic got, input logic exp);
        n_checks++;
        if (got !== exp) begin
            n_fails++;
            $display("FAIL %s %s got %b exp %b at %0t", phase, what, got, exp, $time);
        end
    endtask

    // Reference model: history of input samples, integer run counters.
    logic [5:0] hist[$] = '{6'd0, 6'd0};
    int  m_settle = 0;
    int  m_low    = 0;
    int  m_oc_run = 0;
    bit  m_card   = 1'b0;
    bit  m_oc     = 1'b0;

    always @(posedge clk) begin
        logic [5:0] cur, seen, vis;
        bit pw, rel;
        cur  = rst_n ? {sys_rst_n, clken_pin, oc_raw, rail_good} : 6'd0;
        seen = hist[0];   // value the design acts on at this edge
        vis  = hist[1];   // value visible after this edge
        void'(hist.pop_front());
        hist.push_back(cur);
        if (!rst_n) begin
            m_settle = 0; m_low = 0; m_oc_run = 0; m_card = 0; m_oc = 0;
        end else begin
            pw  = (slot_mode == 3'd4) && (seen[2:0] == 3'b111);
            rel = pw && (m_settle == S_CYC) && seen[5] && seen[4];
            if (m_card) begin
                m_card = rel;
                m_low  = 0;
            end else begin
                m_card = rel && (m_low == W_CYC);
                m_low  = (m_low < W_CYC) ? m_low + 1 : m_low;
            end
            m_settle = pw ? ((m_settle < S_CYC) ? m_settle + 1 : m_settle) : 0;
            if (seen[3] != m_oc) begin
                m_oc_run++;
                if (m_oc_run == D_CYC) begin
                    m_oc = seen[3];
                    m_oc_run = 0;
                end
            end else begin
                m_oc_run = 0;
            end
        end
        #5;
        check_bit("card_rst_n", card_rst_n, m_card);
        check_bit("oc_pull_low", oc_pull_low, m_oc);
        check_bit("clken_pull_low", clken_pull_low,
                  (slot_mode != 3'd0) && !((slot_mode == 3'd4) && (vis[2:0] == 3'b111)));
    end

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 20);
        n_fails++;
        $display("FAIL watchdog got timeout exp completion");
        finish_run();
    end

    initial begin
        // R1: reset values
        phase = "R1";
        wait_cyc(4);
        n_checks++;
        if (card_rst_n !== 1'b0 || oc_pull_low !== 1'b0) begin
            n_fails++;
            $display("FAIL R1 reset got card=%b oc=%b exp card=0 oc=0", card_rst_n, oc_pull_low);
        end
        rst_n = 1'b1;
        wait_cyc(3);

        // R2: each non-powered mode keeps the card in reset
        phase = "R2";
        rail_good = 3'b111;
        slot_mode = 3'd2; wait_cyc(10);
        slot_mode = 3'd3; wait_cyc(10);
        slot_mode = 3'd1; wait_cyc(10);

        // R8: off mode floats the line even with good rails
        phase = "R8";
        slot_mode = 3'd0; wait_cyc(10);

        // R4: powered with good rails releases after the settling run
        phase = "R4";
        slot_mode = 3'd4; wait_cyc(60);

        // R3: a one-cycle rail glitch asserts reset and restarts settling
        phase = "R3";
        rail_good = 3'b101; wait_cyc(1);
        rail_good = 3'b111; wait_cyc(70);

        // R5: long system reset, released fast on return
        phase = "R5";
        sys_rst_n = 1'b0; wait_cyc(30);
        sys_rst_n = 1'b1; wait_cyc(10);

        // R6: short system reset is stretched to the minimum width
        phase = "R6";
        sys_rst_n = 1'b0; wait_cyc(2);
        sys_rst_n = 1'b1; wait_cyc(30);

        // R7: host holds the clock-enable line low
        phase = "R7";
        host_hold = 1'b1; wait_cyc(20);
        host_hold = 1'b0; wait_cyc(30);

        // R2: leaving powered mode for standby asserts reset next edge
        phase = "R2";
        slot_mode = 3'd3; wait_cyc(10);
        slot_mode = 3'd4; wait_cyc(60);

        // R8: rail loss in powered mode pulls the line low
        phase = "R8";
        rail_good = 3'b011; wait_cyc(10);
        rail_good = 3'b111; wait_cyc(60);

        // R9: sustained overcurrent sets then clears the flag
        phase = "R9";
        oc_raw = 1'b1; wait_cyc(50);
        oc_raw = 1'b0; wait_cyc(50);

        // R10: short pulses and a short gap are rejected
        phase = "R10";
        oc_raw = 1'b1; wait_cyc(20);
        oc_raw = 1'b0; wait_cyc(5);
        oc_raw = 1'b1; wait_cyc(20);
        oc_raw = 1'b0; wait_cyc(40);
        oc_raw = 1'b1; wait_cyc(45);
        oc_raw = 1'b0; wait_cyc(10);
        oc_raw = 1'b1; wait_cyc(10);
        oc_raw = 1'b0; wait_cyc(50);

        finish_run();
    end

endmodule